// File: doc/BRIEF.md
# Port-Pin Edge Interrupt Aggregator

This block watches 32 general-purpose port pins, turns qualifying edges on them into latched per-line events, and drives a single interrupt request toward a parent interrupt controller. Each pin is first brought into the clock domain by a two-stage synchroniser. The edge detector then compares two successive synchronised samples. Software programs each line to react either to falling edges alone or to any change of level.

Software reaches the block through a small 32-bit register window on a single-cycle bus. Three registers are mapped: an event register (read pending events, write ones to acknowledge), a mask register (a 1 lets a line reach the output) and an edge-select register. Every register uses the same numbering: line n lives in bit 31−n, so line 0 is the most significant bit. A handler reads the event register and finds the pending line from the leading one. It services the line and then acknowledges it by writing that bit back.

Top module: `pinirq_aggr`

## Requirements
- R1: After reset the event, mask and edge-select registers read as zero and `irq_o` is low.
- R2: The byte offsets are fixed: event register at 0x0C, mask at 0x10, edge-select at 0x14. A read of any other offset returns zero, and a write to any other offset changes no register.
- R3: Line n (pin `pin_i[n]`) appears in bit 31−n of the event, mask and edge-select registers.
- R4: With its edge-select bit at 0, a line records an event on both a rising and a falling pin transition.
- R5: With its edge-select bit at 1, a line records an event on a falling transition only. A rising transition records nothing.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it as it was. Pending events stay latched until they are cleared.
- R7: Events are latched whether or not the line is masked. `irq_o` is high exactly when some event bit and the matching mask bit are both 1, so unmasking a pending line raises `irq_o`.
- R8: If a qualifying edge and a write-1 clear reach the same event bit in the same cycle, the bit stays set.
- R9: A pin change applied before rising clock edge k sets its event bit at rising edge k+2. The bit and `irq_o` still show the old value after edge k+1.
- R10: Pins that are already high when reset is released do not produce events.
- R11: The mask and edge-select registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 32 | Raw port pins; index n is line n |
| bus_addr_i | input | 5 | Byte offset into the register window |
| bus_we_i | input | 1 | Write strobe, takes effect at the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, valid in the same cycle |
| irq_o | output | 1 | Combined interrupt request to the parent controller |

## Verification
The hardest case to reach from the ports is a qualifying edge whose event lands in the same clock cycle as a software acknowledge of that same bit. The synchroniser delay hides the edge inside the block for two cycles. The stimulus therefore sets the bit first and then changes the pin half a cycle before edge k. It then holds the write-1 clear on the bus across edge k+2, the edge at which the event is recorded. A second hard case is a pin that is already high while reset is released. The bench raises every pin during reset and checks that no event appears afterwards.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam int unsigned LINES  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_EVT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h14;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_EVT: sel = SEL_EVT;
      OFS_MSK: sel = SEL_MSK;
      OFS_CTL: sel = SEL_CTL;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/pinirq_rst_sync.sv
module pinirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pinirq_edge.sv
module pinirq_edge #(
  parameter int unsigned LINES = 32,
  parameter int unsigned PRIME = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pin_i,
  input  logic [LINES-1:0] fall_only_i,   // register-bit order
  output logic [LINES-1:0] hit_o          // register-bit order
);

  logic [LINES-1:0] meta_q, sync_q, prev_q;
  logic [LINES-1:0] meta_d, sync_d, prev_d;
  logic [PRIME-1:0] prime_q, prime_d;
  logic             primed;
  logic [LINES-1:0] lvl_bits;

  // next-state
  always_comb begin
    meta_d  = pin_i;
    sync_d  = meta_q;
    prev_d  = sync_q;
    prime_d = {prime_q[PRIME-2:0], 1'b1};
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      sync_q  <= '0;
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      meta_q  <= meta_d;
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      prime_q <= prime_d;
    end
  end

  assign primed = prime_q[PRIME-1];

  for (genvar n = 0; n < LINES; n++) begin : g_line
    localparam int unsigned B = LINES - 1 - n;
    logic rise, fall;
    assign rise        = sync_q[n] & ~prev_q[n];
    assign fall        = ~sync_q[n] & prev_q[n];
    assign hit_o[B]    = primed & (fall | (rise & ~fall_only_i[B]));
    assign lvl_bits[B] = sync_q[n];
  end

  // a falling-only line may only fire while its synchronised level is low
  AST_FALL_ONLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_o & fall_only_i & lvl_bits) == '0)); // R5

  // no hit while the synchroniser is still filling after reset
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (hit_o == '0)); // R10

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int unsigned NL = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [NL-1:0] wdata_i,
  input  logic [NL-1:0] hit_i,
  output logic [NL-1:0] rdata_o,
  output logic [NL-1:0] evt_o,
  output logic [NL-1:0] msk_o,
  output logic [NL-1:0] ctl_o
);

  reg_sel_e      sel;
  logic          evt_en, msk_en, ctl_en, clr_en;
  logic [NL-1:0] evt_q, msk_q, ctl_q;
  logic [NL-1:0] evt_d, msk_d, ctl_d;
  logic [NL-1:0] clr_bits;

  always_comb begin
    sel      = decode_ofs(addr_i);
    clr_en   = we_i && (sel == SEL_EVT);
    msk_en   = we_i && (sel == SEL_MSK);
    ctl_en   = we_i && (sel == SEL_CTL);
    clr_bits = clr_en ? wdata_i : '0;
    evt_en   = clr_en || (hit_i != '0);
    // a new edge overrides a simultaneous acknowledge
    evt_d    = (evt_q & ~clr_bits) | hit_i;
    msk_d    = wdata_i;
    ctl_d    = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else begin
      if (evt_en) evt_q <= evt_d;
      if (msk_en) msk_q <= msk_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_EVT: rdata_o = evt_q;
      SEL_MSK: rdata_o = msk_q;
      SEL_CTL: rdata_o = ctl_q;
      default: rdata_o = '0;
    endcase
  end

  assign evt_o = evt_q;
  assign msk_o = msk_q;
  assign ctl_o = ctl_q;

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_en) |-> (($past(evt_q) & ~evt_q) == '0)); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_i) & ~evt_q) == '0)); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(evt_q) & ~$past(hit_i)) == '0)); // R7

  AST_MSK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(msk_en) |-> $stable(msk_q)); // R11

endmodule

// File: rtl/pinirq_aggr.sv
module pinirq_aggr
  import pinirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  pin_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic             rst_n;
  logic [LINES-1:0] hit, evt, msk, ctl;

  pinirq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  pinirq_edge #(.LINES(LINES), .PRIME(3)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pin_i       (pin_i),
    .fall_only_i (ctl),
    .hit_o       (hit)
  );

  pinirq_regs #(.NL(LINES), .AW(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .hit_i   (hit),
    .rdata_o (bus_rdata_o),
    .evt_o   (evt),
    .msk_o   (msk),
    .ctl_o   (ctl)
  );

  assign irq_o = |(evt & msk);

  // the request only drops after software acknowledged or masked
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> $past(bus_we_i &&
      ((bus_addr_i == OFS_EVT) || (bus_addr_i == OFS_MSK)))); // R7

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o); // R1

endmodule

// File: tb/sim_pinirq_aggr.sv
`timescale 1ns/1ps
module sim_pinirq_aggr;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] pin_i;
  logic [4:0]  bus_addr_i;
  logic        bus_we_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [4:0] A_EVT = 5'h0C;
  localparam logic [4:0] A_MSK = 5'h10;
  localparam logic [4:0] A_CTL = 5'h14;

  // {line[4:0], fall_only, new level, event expected}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {5'd0,  1'b0, 1'b1, 1'b1},
    {5'd0,  1'b0, 1'b0, 1'b1},
    {5'd5,  1'b1, 1'b1, 1'b0},
    {5'd5,  1'b1, 1'b0, 1'b1},
    {5'd31, 1'b0, 1'b1, 1'b1},
    {5'd31, 1'b1, 1'b0, 1'b1},
    {5'd17, 1'b1, 1'b1, 1'b0},
    {5'd17, 1'b0, 1'b0, 1'b1},
    {5'd9,  1'b0, 1'b1, 1'b1},
    {5'd9,  1'b1, 1'b0, 1'b1}
  };

  pinirq_aggr u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_we_i = 1'b0;
    #1 d = bus_rdata_o;
  endtask

  task automatic pin_set(input int line, input logic v);
    @(negedge clk_i);
    pin_i[line] = v;
    repeat (3) @(posedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ctl_sh, exp;
    pin_i = '0; bus_addr_i = '0; bus_we_i = 1'b0; bus_wdata_i = '0;
    do_reset();

    // R1 reset state
    rd(A_EVT, d); check("R1 evt", d, 32'h0);
    rd(A_MSK, d); check("R1 msk", d, 32'h0);
    rd(A_CTL, d); check("R1 ctl", d, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // vector walk: R3 R4 R5, mask 0 so irq stays low (R7)
    ctl_sh = '0;
    for (int i = 0; i < NV; i++) begin
      int ln;
      ln = int'(VEC[i][7:3]);
      ctl_sh[31-ln] = VEC[i][2];
      wr(A_CTL, ctl_sh);
      pin_set(ln, VEC[i][1]);
      rd(A_EVT, d);
      exp = VEC[i][0] ? (32'h1 << (31 - ln)) : 32'h0;
      check(VEC[i][2] ? "R5 R3 fall-only" : "R4 R3 any-edge", d, exp);
      check("R7 masked irq", {31'b0, irq_o}, 32'h0);
      wr(A_EVT, 32'hFFFF_FFFF);
    end

    // R11 readback
    wr(A_CTL, 32'h0);
    wr(A_MSK, 32'hA5A5_0F0F); rd(A_MSK, d); check("R11 msk", d, 32'hA5A5_0F0F);
    wr(A_CTL, 32'h0000_1234); rd(A_CTL, d); check("R11 ctl", d, 32'h0000_1234);
    wr(A_CTL, 32'h0);

    // R2 unmapped offsets
    rd(5'h00, d); check("R2 read 0x00", d, 32'h0);
    rd(5'h18, d); check("R2 read 0x18", d, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(A_MSK, d); check("R2 write 0x08 mask", d, 32'hA5A5_0F0F);
    rd(A_CTL, d); check("R2 write 0x08 ctl", d, 32'h0);
    rd(A_EVT, d); check("R2 write 0x08 evt", d, 32'h0);
    wr(A_MSK, 32'h0);

    // R6 partial acknowledge: lines 1,2 -> bits 30,29
    pin_set(1, 1'b1); pin_set(2, 1'b1);
    rd(A_EVT, d); check("R6 two pending", d, 32'h6000_0000);
    wr(A_EVT, 32'h0); rd(A_EVT, d); check("R6 write zero", d, 32'h6000_0000);
    wr(A_EVT, 32'h4000_0000); rd(A_EVT, d); check("R6 clear one", d, 32'h2000_0000);

    // R7 unmask exposes latched event
    check("R7 masked", {31'b0, irq_o}, 32'h0);
    wr(A_MSK, 32'h0000_0001); #1 check("R7 other mask", {31'b0, irq_o}, 32'h0);
    wr(A_MSK, 32'h2000_0000); #1 check("R7 unmask", {31'b0, irq_o}, 32'h1);
    wr(A_EVT, 32'h2000_0000); #1 check("R7 ack drops", {31'b0, irq_o}, 32'h0);

    // R9 latency on line 3 (bit 28)
    wr(A_MSK, 32'h1000_0000);
    @(negedge clk_i); pin_i[3] = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); check("R9 not yet", {31'b0, irq_o}, 32'h0);
    @(posedge clk_i);
    @(negedge clk_i); check("R9 at k+2", {31'b0, irq_o}, 32'h1);
    wr(A_EVT, 32'h1000_0000); wr(A_MSK, 32'h0);

    // R8 set wins over same-cycle clear, line 4 (bit 27)
    pin_set(4, 1'b1);
    rd(A_EVT, d); check("R8 pre-set", d, 32'h0800_0000);
    @(negedge clk_i); pin_i[4] = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i);
    bus_addr_i = A_EVT; bus_wdata_i = 32'h0800_0000; bus_we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); bus_we_i = 1'b0;
    rd(A_EVT, d); check("R8 set wins", d, 32'h0800_0000);
    wr(A_EVT, 32'h0800_0000); rd(A_EVT, d); check("R8 later clear", d, 32'h0);

    // R10 pins high through reset release
    @(negedge clk_i); rst_ni = 1'b0; pin_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    rd(A_EVT, d); check("R10 no event", d, 32'h0);
    check("R10 irq", {31'b0, irq_o}, 32'h0);
    pin_set(7, 1'b0);
    rd(A_EVT, d); check("R10 live after", d, 32'h0100_0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule